// File: doc/BRIEF.md
# Control-Frame Tag Inserter

A byte-wide streaming stage on the transmit path toward a switch. The host sends frames on an input stream with valid, ready and last. With the first byte of each frame it presents sideband fields: a flag marking the frame as a control frame, the frame's byte length, a 3-bit priority, a 4-bit switch number and the index of the egress port. Ordinary frames cross the block unchanged. A control frame gets a 4-byte tag placed right behind its two MAC addresses and a 4-byte trailer appended after its last byte. This lets the switch route the frame to one port without any out-of-band setup.

The tag is a fixed EtherType 0xDADC followed by a header word. The header word marks the host-to-switch direction and the presence of a trailer. It also carries the byte offset at which the trailer starts. The trailer holds the priority, the switch number and a one-hot port mask. If tagging would make the frame longer than the 11-bit offset field can describe, the frame is sent untagged and a one-cycle error pulse is raised. The block adds no latency: it has no storage on the data path, and while it emits inserted bytes it stalls the input.

Top module: `ctl_tag_inserter`

## Requirements
- R1: A frame whose control flag is 0 leaves the block byte for byte as it entered, with `m_last` on the same byte and no byte added or removed.
- R2: A tagged control frame is output as its first 12 bytes unchanged, then bytes 0xDA and 0xDC, then the 2-byte header word most significant byte first, then all remaining input bytes unchanged, beginning with the frame's original type/length field.
- R3: The header word has bit 15 = 1 (host to switch), bits 14:12 = 0, bit 11 = 1 (trailer present), and bits 10:0 = input frame length + 4.
- R4: After the last input byte, a tagged frame gets a 4-byte trailer, most significant byte first. Trailer bits 23:21 hold the priority, bits 15:12 the switch number, and bits 11:1 a mask with only bit (1 + port index) set, for port indices 0 to 10. All other trailer bits are 0. `m_last` is high only on the final trailer byte.
- R5: The sideband fields are taken only on the first accepted byte of a frame. Changes to them later in the frame do not affect that frame's tagging, header or trailer.
- R6: While `m_valid` is high and `m_ready` is low, `m_data`, `m_valid` and `m_last` hold in the next cycle. `s_ready` is never high while `m_ready` is low. No byte is lost or duplicated under backpressure.
- R7: While the four tag bytes and the four trailer bytes are emitted, `s_ready` is low. Every input byte of a tagged frame appears in the output, so the output holds exactly input length + 8 bytes.
- R8: A control frame whose length + 8 exceeds 2047 is passed through as in R1. `err_o` is high for exactly one cycle, in the cycle after that frame's first byte is accepted. `err_o` never rises for a frame whose control flag is 0.
- R9: During and right after reset, `m_valid` is low while `s_valid` is low, `err_o` is low, and `s_ready` equals `m_ready`.

Control frames are assumed to be at least 13 bytes long, and `sb_len` is assumed to match the number of bytes actually sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_data | input | 8 | Input stream byte |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block accepts the input byte |
| s_last | input | 1 | Input byte is the last of the frame |
| sb_ctrl | input | 1 | Frame is a control frame (valid with the first byte) |
| sb_len | input | 12 | Input frame length in bytes (valid with the first byte) |
| sb_prio | input | 3 | Priority for the trailer |
| sb_swid | input | 4 | Switch number for the trailer |
| sb_port | input | 4 | Destination port index, 0 to 10 |
| m_data | output | 8 | Output stream byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_last | output | 1 | Output byte is the last of the frame |
| err_o | output | 1 | One-cycle pulse: control frame too long to tag |

## Verification
The main function is tried on ordinary frames, on control frames with different priorities, switch numbers and ports (including port 0 and port 10), and on a one-byte ordinary frame. Comparing ordinary and control frames shows whether tagging depends on the flag. The extreme ports show whether the mask lands on the right bit. The minimal 13-byte control frame tests the case where the insertion point sits right next to the frame end. Each frame runs with free flow, with periodic downstream stalls or with input gaps, so that a lost or repeated byte at the insertion point or at the trailer shows up. The sideband is scrambled after the first byte of every frame to expose late sampling. Lengths 2039 and 2040 sit on each side of the size limit, and an ordinary frame of 2040 bytes shows that the error pulse depends on the control flag.

// File: rtl/ctl_tag_pkg.sv
package ctl_tag_pkg;
  // Fixed EtherType announcing the inserted control tag
  localparam logic [15:0] CTL_ETYPE = 16'hDADC;
  // Header word flag positions decoded by the switch
  localparam int HDR_DIR_BIT = 15;
  localparam int HDR_TRL_BIT = 11;
  // Byte counts of inserted pieces
  localparam int TAG_BYTES = 4;
  localparam int TRL_BYTES = 4;
  // Trailer field layout
  localparam int MASK_BITS = 11;
  localparam int POS_W     = 11;
  localparam int PRIO_LSB  = 21;
  localparam int SWID_LSB  = 12;
  localparam int MASK_LSB  = 1;

  typedef enum logic [1:0] {
    SEQ_COPY = 2'd0,
    SEQ_HDR  = 2'd1,
    SEQ_TRL  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ctl_tag_fields.sv
module ctl_tag_fields
  import ctl_tag_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PORT_W     = 4,
  parameter int NUM_PORTS  = 11,
  parameter int MAX_TAGGED = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              sb_ctrl,
  input  logic [LEN_W-1:0]  sb_len,
  input  logic [2:0]        sb_prio,
  input  logic [3:0]        sb_swid,
  input  logic [PORT_W-1:0] sb_port,
  output logic              tag_now,
  output logic              tag_q,
  output logic              err_o,
  output logic [15:0]       hdr_word,
  output logic [31:0]       trl_word
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0]  full_len;
  logic              fits;
  logic              tag_d, err_d;
  logic [POS_W-1:0]  len_q, len_d;
  logic [2:0]        prio_q, prio_d;
  logic [3:0]        swid_q, swid_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [POS_W-1:0]  pos;
  logic [MASK_BITS-1:0] mask;

  // Size check on the live sideband: input length plus tag and trailer
  assign full_len = {1'b0, sb_len} + SUM_W'(TAG_BYTES + TRL_BYTES);
  assign fits     = (full_len <= SUM_W'(MAX_TAGGED));
  assign tag_now  = sb_ctrl & fits;

  // Next-state: capture on the first accepted beat, otherwise hold
  always_comb begin
    tag_d  = tag_q;
    len_d  = len_q;
    prio_d = prio_q;
    swid_d = swid_q;
    port_d = port_q;
    err_d  = cap_en & sb_ctrl & ~fits;
    if (cap_en) begin
      tag_d  = tag_now;
      len_d  = sb_len[POS_W-1:0];
      prio_d = sb_prio;
      swid_d = sb_swid;
      port_d = sb_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= 1'b0;
      len_q  <= '0;
      prio_q <= '0;
      swid_q <= '0;
      port_q <= '0;
    end else if (cap_en) begin
      tag_q  <= tag_d;
      len_q  <= len_d;
      prio_q <= prio_d;
      swid_q <= swid_d;
      port_q <= port_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= err_d;
  end

  // Trailer start offset: frame length once the tag is in place
  assign pos = len_q + POS_W'(TAG_BYTES);

  // One-hot destination mask, one decoder bit per mask position
  for (genvar k = 0; k < MASK_BITS; k++) begin : g_mask
    if (k < NUM_PORTS) begin : g_live
      assign mask[k] = (port_q == PORT_W'(k));
    end else begin : g_dead
      assign mask[k] = 1'b0;
    end
  end

  always_comb begin
    hdr_word              = '0;
    hdr_word[HDR_DIR_BIT] = 1'b1;
    hdr_word[HDR_TRL_BIT] = 1'b1;
    hdr_word[POS_W-1:0]   = pos;
    trl_word                               = '0;
    trl_word[PRIO_LSB +: 3]                = prio_q;
    trl_word[SWID_LSB +: 4]                = swid_q;
    trl_word[MASK_LSB +: MASK_BITS]        = mask;
  end
endmodule

// File: rtl/ctl_tag_seq.sv
module ctl_tag_seq
  import ctl_tag_pkg::*;
#(
  parameter int MAC_BYTES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  input  logic       s_last,
  input  logic       m_ready,
  input  logic       tag_now,
  input  logic       tag_q,
  output logic       s_ready,
  output logic       m_valid,
  output logic       m_last,
  output logic       cap_en,
  output seq_state_t state_o,
  output logic [1:0] idx_o
);
  localparam int CNT_W = $clog2(MAC_BYTES + 1);

  seq_state_t       state_q, state_d;
  logic [1:0]       idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sof_q, sof_d;
  logic             tag_eff, in_acc, ce;

  // On the first beat the captured flag is not loaded yet: use the live one
  assign tag_eff = sof_q ? tag_now : tag_q;
  assign in_acc  = (state_q == SEQ_COPY) & s_valid & m_ready;
  assign cap_en  = in_acc & sof_q;
  assign ce      = in_acc | ((state_q != SEQ_COPY) & m_ready);

  // Handshake and framing outputs
  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b1;
    m_last  = 1'b0;
    unique case (state_q)
      SEQ_COPY: begin
        s_ready = m_ready;
        m_valid = s_valid;
        m_last  = s_last & ~tag_eff;
      end
      SEQ_HDR: m_last = 1'b0;
      SEQ_TRL: m_last = (idx_q == 2'd3);
      default: m_valid = 1'b0;
    endcase
  end

  // Next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    sof_d   = sof_q;
    unique case (state_q)
      SEQ_COPY: begin
        if (in_acc) begin
          sof_d = s_last;
          if (s_last) begin
            cnt_d = '0;
            if (tag_eff) begin
              state_d = SEQ_TRL;
              idx_d   = 2'd0;
            end
          end else begin
            if (cnt_q != CNT_W'(MAC_BYTES)) cnt_d = cnt_q + 1'b1;
            if (tag_eff && (cnt_q == CNT_W'(MAC_BYTES - 1))) begin
              state_d = SEQ_HDR;
              idx_d   = 2'd0;
            end
          end
        end
      end
      SEQ_HDR, SEQ_TRL: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == 2'd3) state_d = SEQ_COPY;
      end
      default: state_d = SEQ_COPY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_COPY;
      idx_q   <= '0;
      cnt_q   <= '0;
      sof_q   <= 1'b1;
    end else if (ce) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      sof_q   <= sof_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/ctl_tag_mux.sv
module ctl_tag_mux
  import ctl_tag_pkg::*;
(
  input  seq_state_t  state,
  input  logic [1:0]  idx,
  input  logic [7:0]  s_data,
  input  logic [15:0] hdr_word,
  input  logic [31:0] trl_word,
  output logic [7:0]  m_data
);
  logic [31:0] tag_word;
  logic [4:0]  sel;

  assign tag_word = {CTL_ETYPE, hdr_word};
  // Big-endian byte order: index 0 takes the top byte
  assign sel      = {~idx, 3'b000};

  always_comb begin
    unique case (state)
      SEQ_HDR: m_data = tag_word[sel +: 8];
      SEQ_TRL: m_data = trl_word[sel +: 8];
      default: m_data = s_data;
    endcase
  end
endmodule

// File: rtl/ctl_tag_inserter.sv
module ctl_tag_inserter
  import ctl_tag_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PORT_W     = 4,
  parameter int NUM_PORTS  = 11,
  parameter int MAC_BYTES  = 12,
  parameter int MAX_TAGGED = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_last,
  input  logic              sb_ctrl,
  input  logic [LEN_W-1:0]  sb_len,
  input  logic [2:0]        sb_prio,
  input  logic [3:0]        sb_swid,
  input  logic [PORT_W-1:0] sb_port,
  output logic [7:0]        m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_last,
  output logic              err_o
);
  logic [1:0]  rst_sync;
  logic        rst_int_n;
  logic        cap_en, tag_now, frame_tag;
  logic [15:0] hdr_word;
  logic [31:0] trl_word;
  seq_state_t  state;
  logic [1:0]  idx;

  // Reset asserts at once and releases two clock edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ctl_tag_fields #(
    .LEN_W(LEN_W), .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .MAX_TAGGED(MAX_TAGGED)
  ) u_fields (
    .clk(clk), .rst_n(rst_int_n), .cap_en(cap_en),
    .sb_ctrl(sb_ctrl), .sb_len(sb_len), .sb_prio(sb_prio),
    .sb_swid(sb_swid), .sb_port(sb_port),
    .tag_now(tag_now), .tag_q(frame_tag), .err_o(err_o),
    .hdr_word(hdr_word), .trl_word(trl_word)
  );

  ctl_tag_seq #(.MAC_BYTES(MAC_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .s_valid(s_valid), .s_last(s_last), .m_ready(m_ready),
    .tag_now(tag_now), .tag_q(frame_tag),
    .s_ready(s_ready), .m_valid(m_valid), .m_last(m_last),
    .cap_en(cap_en), .state_o(state), .idx_o(idx)
  );

  ctl_tag_mux u_mux (
    .state(state), .idx(idx), .s_data(s_data),
    .hdr_word(hdr_word), .trl_word(trl_word), .m_data(m_data)
  );
endmodule

// File: rtl/ctl_tag_inserter_chk.sv
module ctl_tag_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic [7:0] m_data,
  input logic       m_valid,
  input logic       m_ready,
  input logic       m_last,
  input logic       err_o,
  input logic       frame_tag
);
  // Output byte position within the current frame, counted at the port
  logic [15:0] oc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          oc <= '0;
    else if (m_valid && m_ready) begin
      if (m_last)                        oc <= '0;
      else if (oc != 16'hFFFF)           oc <= oc + 16'd1;
    end
  end

  // R6: a stalled output byte is held unchanged
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R6: input is never taken while the output is blocked
  p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> m_ready);

  // R8: an error pulse follows an accepted input byte
  p_err_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(s_valid && s_ready));

  // R2: the first inserted byte is the top EtherType byte
  p_etype_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && frame_tag && oc == 16'd12) |-> (m_data == 8'hDA));

  // R3: header high byte carries direction and trailer flags
  p_hdr_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && frame_tag && oc == 16'd14) |-> (m_data[7] && m_data[3] && m_data[6:4] == 3'b000));

  // R7: input stalls while tag bytes go out
  p_ins_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && frame_tag && oc >= 16'd12 && oc <= 16'd15) |-> !s_ready);
endmodule

bind ctl_tag_inserter ctl_tag_inserter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last),
  .err_o(err_o), .frame_tag(frame_tag)
);

// File: tb/test_ctl_tag_inserter.sv
module test_ctl_tag_inserter;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [7:0] s_data;
  logic       s_valid, s_ready, s_last;
  logic       sb_ctrl;
  logic [11:0] sb_len;
  logic [2:0] sb_prio;
  logic [3:0] sb_swid, sb_port;
  logic [7:0] m_data;
  logic       m_valid, m_ready, m_last, err_o;

  ctl_tag_inserter i_ctl_tag_inserter (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .sb_ctrl(sb_ctrl), .sb_len(sb_len), .sb_prio(sb_prio),
    .sb_swid(sb_swid), .sb_port(sb_port), .m_data(m_data), .m_valid(m_valid),
    .m_ready(m_ready), .m_last(m_last), .err_o(err_o)
  );

  typedef struct packed {
    logic        ctrl;
    logic [11:0] len;
    logic [2:0]  prio;
    logic [3:0]  swid;
    logic [3:0]  port;
    logic        stall;
    logic        gap;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'd20,   3'd0, 4'd0,  4'd0,  1'b0, 1'b0},
    '{1'b1, 12'd60,   3'd5, 4'd9,  4'd0,  1'b0, 1'b0},
    '{1'b1, 12'd14,   3'd7, 4'd15, 4'd10, 1'b1, 1'b0},
    '{1'b0, 12'd64,   3'd3, 4'd2,  4'd1,  1'b1, 1'b1},
    '{1'b1, 12'd13,   3'd0, 4'd0,  4'd3,  1'b1, 1'b1},
    '{1'b1, 12'd100,  3'd2, 4'd4,  4'd7,  1'b0, 1'b1},
    '{1'b0, 12'd1,    3'd0, 4'd0,  4'd0,  1'b1, 1'b0},
    '{1'b1, 12'd2039, 3'd1, 4'd6,  4'd5,  1'b0, 1'b0},
    '{1'b1, 12'd2040, 3'd4, 4'd8,  4'd2,  1'b0, 1'b0},
    '{1'b0, 12'd2040, 3'd6, 4'd1,  4'd9,  1'b1, 1'b0}
  };

  int total, bad, cyc, err_cnt, exp_n, got_n;
  bit err_watch;
  logic [7:0] exp_b [0:2100];
  logic [7:0] got_b [0:2100];

  always @(negedge clk) begin
    cyc++;
    if (err_watch && err_o) err_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] din(input int v, input int i);
    return 8'(i * 13 + v * 37 + 5);
  endfunction

  function automatic bit is_tagged(input vec_t t);
    return t.ctrl && (int'(t.len) + 8 <= 2047);
  endfunction

  task automatic build_exp(input int v, input vec_t t);
    logic [15:0] hdr;
    logic [31:0] trl;
    exp_n = 0;
    if (!is_tagged(t)) begin
      for (int i = 0; i < int'(t.len); i++) begin exp_b[exp_n] = din(v, i); exp_n++; end
    end else begin
      hdr = 16'h8800 | 16'(t.len + 12'd4);
      trl = (32'(t.prio) << 21) | (32'(t.swid) << 12) | (32'd1 << (t.port + 1));
      for (int i = 0; i < 12; i++) begin exp_b[exp_n] = din(v, i); exp_n++; end
      exp_b[exp_n] = 8'hDA; exp_b[exp_n+1] = 8'hDC;
      exp_b[exp_n+2] = hdr[15:8]; exp_b[exp_n+3] = hdr[7:0];
      exp_n += 4;
      for (int i = 12; i < int'(t.len); i++) begin exp_b[exp_n] = din(v, i); exp_n++; end
      for (int k = 0; k < 4; k++) begin exp_b[exp_n] = trl[31-8*k -: 8]; exp_n++; end
    end
  endtask

  task automatic drive_frame(input int v, input vec_t t);
    for (int i = 0; i < int'(t.len); i++) begin
      if (t.gap && (i % 5 == 2)) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1;
      s_data  = din(v, i);
      s_last  = (i == int'(t.len) - 1);
      if (i == 0) begin
        sb_ctrl = t.ctrl; sb_len = t.len; sb_prio = t.prio;
        sb_swid = t.swid; sb_port = t.port;
      end else begin
        // R5: scramble sideband after the first beat
        sb_ctrl = ~t.ctrl; sb_len = ~t.len; sb_prio = ~t.prio;
        sb_swid = ~t.swid; sb_port = 4'(t.port + 4'd5);
      end
      #1;
      while (!s_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic collect(input vec_t t);
    bit done;
    done  = 1'b0;
    got_n = 0;
    while (!done) begin
      m_ready = t.stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (m_valid && m_ready) begin
        if (got_n < 2100) got_b[got_n] = m_data;
        got_n++;
        if (m_last) done = 1'b1;
      end
      @(negedge clk);
    end
    m_ready = 1'b1;
  endtask

  function automatic string region(input bit tg, input int p, input int n);
    if (!tg) return "R1";
    if (p >= 14 && p < 16) return "R3";
    if (p >= n - 4) return "R4";
    return "R2";
  endfunction

  task automatic run_vec(input int v, input vec_t t);
    bit tg;
    int mism;
    logic [15:0] ghdr;
    logic [31:0] gtrl;
    tg = is_tagged(t);
    build_exp(v, t);
    err_cnt   = 0;
    err_watch = 1'b1;
    fork
      drive_frame(v, t);
      collect(t);
    join
    repeat (3) @(negedge clk);
    err_watch = 1'b0;

    check(got_n == exp_n, tg ? "R7" : "R1", "output length", got_n, exp_n);
    if (got_n == exp_n) begin
      mism = -1;
      for (int i = 0; i < exp_n; i++)
        if (mism < 0 && got_b[i] !== exp_b[i]) mism = i;
      if (mism >= 0)
        check(1'b0, region(tg, mism, exp_n), "byte value", got_b[mism], exp_b[mism]);
      else
        check(1'b1, region(tg, 0, exp_n), "bytes", 0, 0);
      if (t.stall || t.gap) check(mism < 0, "R6", "bytes under stall", mism, -1);
      if (tg) begin
        ghdr = {got_b[14], got_b[15]};
        gtrl = {got_b[exp_n-4], got_b[exp_n-3], got_b[exp_n-2], got_b[exp_n-1]};
        check(ghdr == (16'h8800 | 16'(t.len + 12'd4)), "R3", "header word", ghdr,
              16'h8800 | 16'(t.len + 12'd4));
        check(gtrl == ((32'(t.prio) << 21) | (32'(t.swid) << 12) | (32'd1 << (t.port + 1))),
              "R4", "trailer word", gtrl,
              (32'(t.prio) << 21) | (32'(t.swid) << 12) | (32'd1 << (t.port + 1)));
        check(ghdr[10:0] == 11'(t.len + 12'd4), "R5", "first-beat length used",
              ghdr[10:0], 11'(t.len + 12'd4));
      end else if (t.ctrl) begin
        check(got_b[12] == din(v, 12), "R8", "oversize untouched", got_b[12], din(v, 12));
      end else begin
        check(got_b[0] == din(v, 0), "R5", "late sideband ignored", got_b[0], din(v, 0));
      end
    end
    check(err_cnt == ((t.ctrl && !tg) ? 1 : 0), "R8", "error pulse cycles", err_cnt,
          (t.ctrl && !tg) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; cyc = 0; err_cnt = 0; err_watch = 1'b0;
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    sb_ctrl = 1'b0; sb_len = '0; sb_prio = '0; sb_swid = '0; sb_port = '0;
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(m_valid == 1'b0, "R9", "m_valid in reset", m_valid, 0);
    check(err_o == 1'b0, "R9", "err_o in reset", err_o, 0);
    check(s_ready == 1'b1, "R9", "s_ready follows m_ready=1", s_ready, 1);
    m_ready = 1'b0;
    #1;
    check(s_ready == 1'b0, "R9", "s_ready follows m_ready=0", s_ready, 0);
    m_ready = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(m_valid == 1'b0 && err_o == 1'b0, "R9", "idle after reset",
          {m_valid, err_o}, 0);
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_vec(v, VECS[v]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule